// File: doc/BRIEF.md
# Symmetric PWM Timer Channel

This block is an 8-bit timer channel that sweeps a counter from zero up to its top value and back down again. It drives one output pin whose pulse is centred on the bottom of each sweep, so the edges of the output are symmetric in time. A programmable divider sets the speed of the sweep. The divider turns the system clock into a count enable: every cycle, every 8th, 64th, 256th or 1024th enabled cycle. A full up-and-down sweep takes 510 enables, so the pin frequency is the clock frequency divided by (N × 510).

Software writes a compare value into a holding register. The channel moves that value into the active compare register only at the top of a sweep, so a write never cuts a pulse short. When the counter passes the compare value on the way up, the pin goes low. When it passes the compare value on the way down, the pin goes high. An invert input flips the pin. The channel also forces the level that a crossing would have produced at the top and at the bottom of each sweep. This keeps the waveform correct when the compare value changes or a crossing is skipped. Two sticky flags record each return to the bottom and each compare match, and a write of 1 clears each one.

Top module: `pcpwm_channel`

## Requirements
- R1: On each count enable the counter steps by one, from 0 up to 255 and then down to 0, and reverses at each end. One full cycle therefore lasts 510 enables. Without an enable the counter holds its value.
- R2: Let C be the active compare value and n the count reached on an enable, with C between 1 and 254. If the step was upward, the non-inverted level after the enable is high when n < C. If the step was downward, it is high when n ≤ C. In all other cases it is low.
- R3: When `invert` is 1, `pwm_out` is the complement of the non-inverted level. The change takes effect in the same cycle.
- R4: An active compare value of 0 gives a constant low non-inverted level. An active compare value of 255 gives a constant high non-inverted level.
- R5: A write to `cmp_wr` goes only to the holding register. The holding value becomes active on the enable on which the count reaches 255. On that enable the level is low, which is the result of an upward crossing, unless the new value is 255. On the enable on which the count reaches 0 the level is high, unless the active value is 0.
- R6: `ovf_flag` is set on the enable on which the count reaches 0. It stays set until a cycle with `clr_ovf` = 1. If a set and a clear fall in the same cycle, the set wins.
- R7: `div_sel` values 0, 1, 2, 3 and 4 give an enable every 1, 8, 64, 256 and 1024 cycles in which `run` is 1. Values 5 to 7 stop the timer. When `run` is 0 the divider, the counter and the output all hold. A change of `div_sel` never produces two enables in consecutive cycles unless the new divide factor is 1.
- R8: `match_flag` is set on the enable on which the count reaches the active compare value. It is cleared by `clr_match` = 1, and a set wins over a clear in the same cycle.
- R9: After reset the count is 0 and counting upward. The active compare value, the holding register and the divider are all 0. Both flags are 0 and the non-inverted level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Timer enable |
| div_sel | input | 3 | Divide factor select (0:/1, 1:/8, 2:/64, 3:/256, 4:/1024, 5-7: stopped) |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| invert | input | 1 | 1 selects the inverted output |
| clr_ovf | input | 1 | Write-1 clear for the overflow flag |
| clr_match | input | 1 | Write-1 clear for the match flag |
| count | output | 8 | Current counter value |
| pwm_out | output | 1 | Waveform pin |
| ovf_flag | output | 1 | Sticky flag, set on reaching 0 |
| match_flag | output | 1 | Sticky flag, set on compare match |

## Verification
Two pairs of actions can land in the same cycle. In the first, a flag clear arrives on the same enable that sets the flag. In the second, a write to the holding register arrives on the enable on which the counter reaches the top and loads the old holding value. The first pair is forced by holding both clears high for a full sweep; the flag must still read 1 after each bottom and each match. The second pair comes from random writes spread over tens of thousands of enables. A bench model settles each case: the set wins, and the load takes the holding value from before the write. The model gives the expected count, pin level and flags after every cycle.

// File: rtl/pcpwm_pkg.sv
// Package: shared select encoding for the divider of the symmetric PWM channel.
// Assumes nothing beyond the encodings listed in the brief.
package pcpwm_pkg;

    typedef enum logic [2:0] {
        DIV_1    = 3'd0,
        DIV_8    = 3'd1,
        DIV_64   = 3'd2,
        DIV_256  = 3'd3,
        DIV_1024 = 3'd4
    } div_sel_e;

    // Number of low divider bits that must all be 1 for an enable; -1 = stopped.
    function automatic int div_shift(input logic [2:0] sel);
        case (sel)
            DIV_1:    return 0;
            DIV_8:    return 3;
            DIV_64:   return 6;
            DIV_256:  return 8;
            DIV_1024: return 10;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
// Module: free-running divider that turns the system clock into a one-cycle
// count enable. Assumes PRE_W covers the largest shift (10). The divider only
// advances while run is high, and resets with the timer.
module pcpwm_prescaler
    import pcpwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;
    logic             sel_ok;

    // Purpose: build the low-bit mask for the selected divide factor.
    always_comb begin
        int sh;
        sh     = div_shift(sel);
        sel_ok = (sh >= 0);
        mask   = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < sh) mask[i] = 1'b1;
        end
    end

    // Purpose: advance the divider on every enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_q <= '0;
        else if (run) div_q <= div_q + 1'b1;
    end

    assign tick = run && sel_ok && ((div_q & mask) == mask);

    // R7: once a tick comes at a divide factor above 1, the next cycle cannot tick unless the new factor is 1
    assert_no_double_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != DIV_1) |=> (!tick || sel == DIV_1));

    // R7: the divider freezes while the timer is disabled
    assert_frozen_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(div_q));

endmodule

// File: rtl/pcpwm_updown.sv
// Module: up/down sweep counter with direction state and a sticky flag set on
// reaching bottom. Assumes tick lasts one cycle; all state changes on tick only.
module pcpwm_updown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             mov_up,
    output logic             ovf_flag
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT = '0;

    logic up_q;
    logic hit_bot;

    assign mov_up  = up_q;
    assign cnt_nx  = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
    assign hit_bot = tick && (cnt_nx == BOT);

    // Purpose: step the count and reverse the direction at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= BOT;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_nx;
            if (cnt_nx == TOP)      up_q <= 1'b0;
            else if (cnt_nx == BOT) up_q <= 1'b1;
        end
    end

    // Purpose: sticky bottom flag, the set wins over the write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (hit_bot) ovf_flag <= 1'b1;
        else if (clr_ovf) ovf_flag <= 1'b0;
    end

    // R1: every enable moves the count by exactly one
    assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));

    // R1: no enable, no movement
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R1: direction at the two ends
    assert_top_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |-> !up_q);
    assert_bot_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == BOT) |-> up_q);

    // R6: reaching bottom on an enable leaves the flag set
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == BOT + 1'b1 && !up_q) |=> ovf_flag);

endmodule

// File: rtl/pcpwm_compare.sv
// Module: double-buffered compare register, waveform level and sticky match
// flag. Assumes cnt_nx/mov_up describe the step taken on the current tick.
// The level is forced at top and bottom so that missed crossings are repaired.
module pcpwm_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic             mov_up,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             clr_match,
    output logic             wave_q,
    output logic             match_flag
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT = '0;

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             at_top;
    logic             wave_nx;

    assign at_top  = (cnt_nx == TOP);
    assign cmp_eff = at_top ? hold_q : act_q;

    // Purpose: select the level after this step from the crossing rules.
    always_comb begin
        wave_nx = wave_q;
        if (cmp_eff == BOT)          wave_nx = 1'b0;
        else if (cmp_eff == TOP)     wave_nx = 1'b1;
        else if (at_top)             wave_nx = 1'b0;
        else if (cnt_nx == BOT)      wave_nx = 1'b1;
        else if (cnt_nx == cmp_eff)  wave_nx = !mov_up;
    end

    // Purpose: holding register takes writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (cmp_wr) hold_q <= cmp_wdata;
    end

    // Purpose: active compare and level change only on enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            wave_q <= 1'b0;
        end else if (tick) begin
            act_q  <= cmp_eff;
            wave_q <= wave_nx;
        end
    end

    // Purpose: sticky match flag, the set wins over the write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          match_flag <= 1'b0;
        else if (tick && cnt_nx == cmp_eff)  match_flag <= 1'b1;
        else if (clr_match)                  match_flag <= 1'b0;
    end

    // R5: the holding value becomes active on the step that reaches top
    assert_top_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top) |=> act_q == $past(hold_q));

    // R5: the active value never moves away from top
    assert_act_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || !at_top) |=> $stable(act_q));

    // R5: the level at top is the upward-crossing result unless compare is top
    assert_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top && hold_q != TOP) |=> !wave_q);

    // R4: compare at bottom keeps the level low
    assert_const_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_eff == BOT) |=> !wave_q);

    // R8: a match on an enable leaves the flag set
    assert_match_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_nx == act_q && !at_top) |=> match_flag);

endmodule

// File: rtl/pcpwm_channel.sv
// Module: top of the symmetric PWM timer channel. Connects the divider, the
// sweep counter and the compare/output unit; applies the output inversion.
// Assumes a single clock domain and a synchronous active-low reset.
module pcpwm_channel #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [2:0]       div_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             invert,
    input  logic             clr_ovf,
    input  logic             clr_match,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             match_flag
);

    logic             tick;
    logic [CNT_W-1:0] cnt_nx;
    logic             mov_up;
    logic             wave;

    pcpwm_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (div_sel),
        .tick  (tick)
    );

    pcpwm_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr_ovf  (clr_ovf),
        .cnt_q    (count),
        .cnt_nx   (cnt_nx),
        .mov_up   (mov_up),
        .ovf_flag (ovf_flag)
    );

    pcpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cnt_nx     (cnt_nx),
        .mov_up     (mov_up),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .clr_match  (clr_match),
        .wave_q     (wave),
        .match_flag (match_flag)
    );

    assign pwm_out = wave ^ invert;

    // R3: inversion is a pure complement of the internal level
    assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        invert |-> (pwm_out != wave));

endmodule

// File: tb/pcpwm_channel_test.sv
module pcpwm_channel_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       invert = 1'b0;
    logic       clr_ovf = 1'b0;
    logic       clr_match = 1'b0;
    logic [7:0] count;
    logic       pwm_out;
    logic       ovf_flag;
    logic       match_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R9";

    // bench model state
    int m_pre, m_cnt, m_hold, m_act;
    bit m_up, m_lvl, m_ovf, m_mf;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcpwm_channel uut (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .invert(invert),
        .clr_ovf(clr_ovf), .clr_match(clr_match), .count(count),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .match_flag(match_flag)
    );

    function automatic int sel_mask(input int s);
        case (s)
            0: return 0;
            1: return 7;
            2: return 63;
            3: return 255;
            4: return 1023;
            default: return -1;
        endcase
    endfunction

    // expected level from the crossing rules of R2, R4
    function automatic bit exp_level(input int n, input int c, input bit up_step);
        if (c == 0)   return 1'b0;
        if (c == 255) return 1'b1;
        if (up_step)  return (n < c);
        return (n <= c);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) %s got %0d expected %0d",
                     req, phase, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_pre = 0; m_cnt = 0; m_hold = 0; m_act = 0;
        m_up = 1'b1; m_lvl = 1'b0; m_ovf = 1'b0; m_mf = 1'b0;
    endtask

    // one cycle: drive, predict, clock, compare
    task automatic step(input bit en, input int sel, input bit wr, input int wd,
                        input bit inv, input bit co, input bit cm);
        bit tk, mv, sov, smf;
        int mask, n, ca;
        run = en; div_sel = 3'(sel); cmp_wr = wr; cmp_wdata = 8'(wd);
        invert = inv; clr_ovf = co; clr_match = cm;
        mask = sel_mask(sel);
        tk = en && (mask >= 0) && ((m_pre & mask) == mask);
        if (en) m_pre = (m_pre + 1) % 1024;
        sov = 1'b0; smf = 1'b0;
        if (tk) begin
            mv = m_up;
            n  = mv ? m_cnt + 1 : m_cnt - 1;
            if (n == 255) m_up = 1'b0;
            if (n == 0)   m_up = 1'b1;
            ca = (n == 255) ? m_hold : m_act;
            m_act = ca;
            m_lvl = exp_level(n, ca, mv);
            sov = (n == 0);
            smf = (n == ca);
            m_cnt = n;
        end
        if (sov) m_ovf = 1'b1; else if (co) m_ovf = 1'b0;
        if (smf) m_mf = 1'b1;  else if (cm) m_mf = 1'b0;
        if (wr) m_hold = wd;
        @(posedge clk);
        @(negedge clk);
        chk(count == 8'(m_cnt), "R1", "count", count, m_cnt);
        chk(pwm_out == (m_lvl ^ inv), "R2", "pwm_out", pwm_out, m_lvl ^ inv);
        chk(ovf_flag == m_ovf, "R6", "ovf_flag", ovf_flag, m_ovf);
        chk(match_flag == m_mf, "R8", "match_flag", match_flag, m_mf);
    endtask

    task automatic run_n(input int cycles, input int sel, input bit inv,
                         input bit co, input bit cm);
        for (int i = 0; i < cycles; i++) step(1'b1, sel, 1'b0, 0, inv, co, cm);
    endtask

    initial begin
        int r, seed_dummy;
        int sel_r;
        bit inv_r;
        seed_dummy = $urandom(32'h1A2B3C4D);

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(count == 8'd0, "R9", "count after reset", count, 0);
        chk(pwm_out == 1'b0, "R9", "pwm_out after reset", pwm_out, 0);
        chk(ovf_flag == 1'b0, "R9", "ovf_flag after reset", ovf_flag, 0);
        chk(match_flag == 1'b0, "R9", "match_flag after reset", match_flag, 0);

        // R4: compare 0 gives constant low over a full sweep
        phase = "R4";
        run_n(600, 0, 1'b0, 1'b0, 1'b0);
        // R4: compare 255 gives constant high once loaded at top
        step(1'b1, 0, 1'b1, 255, 1'b0, 1'b0, 1'b0);
        run_n(1100, 0, 1'b0, 1'b0, 1'b0);

        // R5: leaving 255 forces the upward-crossing level at top
        phase = "R5";
        step(1'b1, 0, 1'b1, 100, 1'b0, 1'b0, 1'b0);
        run_n(1100, 0, 1'b0, 1'b1, 1'b1);

        // R2: interior compare values
        phase = "R2";
        step(1'b1, 0, 1'b1, 1, 1'b0, 1'b0, 1'b0);
        run_n(1100, 0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 0, 1'b1, 254, 1'b0, 1'b0, 1'b0);
        run_n(1100, 0, 1'b0, 1'b0, 1'b0);

        // R3: inverted output
        phase = "R3";
        step(1'b1, 0, 1'b1, 37, 1'b1, 1'b0, 1'b0);
        run_n(1100, 0, 1'b1, 1'b0, 1'b0);

        // R6 and R8: clears held high, sets must still win
        phase = "R6";
        run_n(600, 0, 1'b0, 1'b1, 1'b1);
        phase = "R8";
        run_n(20, 0, 1'b0, 1'b0, 1'b0);

        // R7: freeze with run low, then each divide factor
        phase = "R7";
        for (int i = 0; i < 50; i++) step(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        run_n(4000, 1, 1'b0, 1'b0, 1'b0);
        run_n(4000, 2, 1'b0, 1'b0, 1'b0);
        run_n(3000, 3, 1'b0, 1'b0, 1'b0);
        run_n(5000, 4, 1'b0, 1'b0, 1'b0);
        run_n(300, 5, 1'b0, 1'b0, 1'b0);
        run_n(300, 7, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3000; i++) step(1'b1, $urandom_range(0, 4), 1'b0, 0,
                                            1'b0, 1'b0, 1'b0);

        // mixed random traffic
        phase = "RAND";
        sel_r = 0; inv_r = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            bit en_r, wr_r, co_r, cm_r;
            r = $urandom_range(0, 999);
            if (r < 2) sel_r = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 0;
            if ($urandom_range(0, 299) == 0) inv_r = !inv_r;
            en_r = ($urandom_range(0, 99) != 0);
            wr_r = ($urandom_range(0, 49) == 0);
            co_r = ($urandom_range(0, 19) == 0);
            cm_r = ($urandom_range(0, 19) == 0);
            r = $urandom_range(0, 9);
            step(en_r, sel_r, wr_r, (r == 0) ? 0 : (r == 1) ? 255 : $urandom_range(0, 255),
                 inv_r, co_r, cm_r);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule